// File: doc/BRIEF.md
# Power Management Control and Status Register

This block holds the 16-bit power management control and status word of one bus-attached peripheral function. Software reaches it through a plain write port with two byte enables and a combinational read-back. The block drives three outputs: the current power state, a wake request, and a one-cycle internal reset for the rest of the function. That reset fires when software moves the function from D3hot back to D0.

The block tracks three kinds of state, and each is cleared by a different reset:

- **Sticky wake status.** It is set by the wake-event input and cleared by software writing 1. When wake is enabled it is context state that only global reset clears. When wake is disabled, bus reset clears it as well.
- **Wake enable.** Only global reset clears it.
- **Power state.** Software writes it. Either reset returns it to D0.

The internal reset pulse leaves every bit of this register untouched.

The power state is kept by a four-state machine: PS_D0, PS_D1, PS_D2 and PS_D3HOT.

- **WRITE transition.** A write to the low byte lane moves the machine from its current state to the state encoded in data bits 1:0.
- **RESET transition.** Either reset returns the machine to PS_D0.
- **D3-EXIT transition.** This is the WRITE transition from PS_D3HOT to PS_D0. Only this transition raises the internal reset pulse.

Both resets are synchronous and active high. Global reset takes priority over bus reset.

Top module: `pm_csr_top`

## Requirements
- R1: While global reset is high at a clock edge, the read value becomes 0000h. Wake request and the internal reset pulse are 0 after that edge.
- R2: Bits 14:9 and 7:2 always read as 0. Writing ones to them changes nothing.
- R3: Bits 1:0 hold the power state, encoded 00 = D0, 01 = D1, 10 = D2, 11 = D3hot. A write with byte enable 0 set loads them from data bits 1:0. A bus reset returns them to 00.
- R4: Bit 8 is the wake enable. A write with byte enable 1 set loads it from data bit 8. Bus reset leaves it unchanged.
- R5: A wake-event input high at a clock edge that is not in a reset cycle sets bit 15. This happens whatever the value of bit 8.
- R6: A write with byte enable 1 set and data bit 15 = 1 clears bit 15. Data bit 15 = 0 leaves it unchanged. If a wake event arrives in the same cycle, bit 15 stays set.
- R7: The wake request output is 1 exactly while bits 15 and 8 both read 1.
- R8: In a bus-reset cycle, bit 15 is cleared if bit 8 is 0 and is kept if bit 8 is 1. Writes and wake events in a bus-reset cycle have no effect.
- R9: The internal reset pulse is high for exactly the one cycle after a write with byte enable 0 that moves bits 1:0 from 11 to 00. No other write or transition raises it. The pulse changes no register bit.
- R10: Each write updates only the byte lanes whose enables are set. Lane 0 covers bits 7:0 and lane 1 covers bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| gl_rst | input | 1 | Global reset, synchronous, active high |
| bus_rst | input | 1 | Bus reset, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte enables (bit 0 for bits 7:0, bit 1 for bits 15:8) |
| wr_data | input | 16 | Write data |
| wake_evt | input | 1 | Wake event from the function |
| rd_data | output | 16 | Current register value |
| wake_req | output | 1 | Wake request |
| pwr_state | output | 2 | Current power state |
| fn_rst_pulse | output | 1 | One-cycle internal function reset |

## Verification
The bench targets the following corner cases; each bullet says what a design that got it wrong would do:
- **Bus reset with wake enabled.** A design that treats bus reset uniformly would lose the sticky status, or would clear the enable.
- **Wake event colliding with a write-1 clear.** A design that lets the clear win would drop a wake that really happened.
- **D3hot exit.** The bench compares it against D3hot-to-D1, D3hot-to-D3hot and lane-0-masked writes. A design that decodes only the new state or ignores byte enables would pulse wrongly, or would disturb the register.
- **Ones written to read-only bits.** A design that stored them would show them in the read value.

// File: rtl/pm_csr_pkg.sv
package pm_csr_pkg;
    localparam int CSR_W    = 16;
    localparam int LANE_W   = 8;
    localparam int BE_W     = CSR_W / LANE_W;
    localparam int PS_W     = 2;
    localparam int STAT_BIT = 15;
    localparam int EN_BIT   = 8;
    localparam int LANE_LO  = 0;
    localparam int LANE_HI  = 1;

    typedef enum logic [PS_W-1:0] {
        PS_D0    = 2'b00,
        PS_D1    = 2'b01,
        PS_D2    = 2'b10,
        PS_D3HOT = 2'b11
    } pstate_e;
endpackage

// File: rtl/pm_pstate_fsm.sv
module pm_pstate_fsm
    import pm_csr_pkg::*;
(
    input  logic            clk,
    input  logic            gl_rst,
    input  logic            bus_rst,
    input  logic            wr_lo,
    input  logic [PS_W-1:0] wr_ps,
    output logic [PS_W-1:0] ps,
    output logic            fn_rst
);
    pstate_e state_q;
    pstate_e state_d;
    logic    d3_exit;
    logic    fn_rst_q;
    logic    any_rst;

    assign any_rst = gl_rst | bus_rst;

    // next state and D3-EXIT detection
    always_comb begin
        state_d = state_q;
        d3_exit = 1'b0;
        unique case (state_q)
            PS_D0, PS_D1, PS_D2: begin
                if (wr_lo) state_d = pstate_e'(wr_ps);
            end
            PS_D3HOT: begin
                if (wr_lo) begin
                    state_d = pstate_e'(wr_ps);
                    d3_exit = (pstate_e'(wr_ps) == PS_D0);
                end
            end
            default: state_d = PS_D0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (any_rst) state_q <= PS_D0;
        else         state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (any_rst) fn_rst_q <= 1'b0;
        else         fn_rst_q <= d3_exit;
    end

    assign ps     = state_q;
    assign fn_rst = fn_rst_q;
endmodule

// File: rtl/pm_wake_ctl.sv
module pm_wake_ctl (
    input  logic clk,
    input  logic gl_rst,
    input  logic bus_rst,
    input  logic wr_hi,
    input  logic wr_stat_bit,
    input  logic wr_en_bit,
    input  logic wake_evt,
    output logic stat,
    output logic en,
    output logic req
);
    logic stat_q;
    logic en_q;
    logic clr_req;

    assign clr_req = wr_hi & wr_stat_bit;

    always_ff @(posedge clk) begin
        if (gl_rst)           en_q <= 1'b0;
        else if (bus_rst)     en_q <= en_q;
        else if (wr_hi)       en_q <= wr_en_bit;
    end

    always_ff @(posedge clk) begin
        if (gl_rst)           stat_q <= 1'b0;
        else if (bus_rst)     stat_q <= stat_q & en_q;
        else                  stat_q <= wake_evt | (stat_q & ~clr_req);
    end

    assign stat = stat_q;
    assign en   = en_q;
    assign req  = stat_q & en_q;
endmodule

// File: rtl/pm_rd_mux.sv
module pm_rd_mux
    import pm_csr_pkg::*;
(
    input  logic            stat,
    input  logic            en,
    input  logic [PS_W-1:0] ps,
    output logic [CSR_W-1:0] rd
);
    always_comb begin
        rd = '0;
        rd[STAT_BIT]  = stat;
        rd[EN_BIT]    = en;
        rd[PS_W-1:0]  = ps;
    end
endmodule

// File: rtl/pm_csr_top.sv
module pm_csr_top
    import pm_csr_pkg::*;
(
    input  logic             clk,
    input  logic             gl_rst,
    input  logic             bus_rst,
    input  logic             wr_en,
    input  logic [BE_W-1:0]  wr_be,
    input  logic [CSR_W-1:0] wr_data,
    input  logic             wake_evt,
    output logic [CSR_W-1:0] rd_data,
    output logic             wake_req,
    output logic [PS_W-1:0]  pwr_state,
    output logic             fn_rst_pulse
);
    logic [BE_W-1:0] lane_we;
    logic            stat_w;
    logic            en_w;
    logic [PS_W-1:0] ps_w;

    for (genvar i = 0; i < BE_W; i++) begin : g_lane
        assign lane_we[i] = wr_en & wr_be[i];
    end

    pm_pstate_fsm u_fsm (
        .clk    (clk),
        .gl_rst (gl_rst),
        .bus_rst(bus_rst),
        .wr_lo  (lane_we[LANE_LO]),
        .wr_ps  (wr_data[PS_W-1:0]),
        .ps     (ps_w),
        .fn_rst (fn_rst_pulse)
    );

    pm_wake_ctl u_wake (
        .clk        (clk),
        .gl_rst     (gl_rst),
        .bus_rst    (bus_rst),
        .wr_hi      (lane_we[LANE_HI]),
        .wr_stat_bit(wr_data[STAT_BIT]),
        .wr_en_bit  (wr_data[EN_BIT]),
        .wake_evt   (wake_evt),
        .stat       (stat_w),
        .en         (en_w),
        .req        (wake_req)
    );

    pm_rd_mux u_mux (
        .stat(stat_w),
        .en  (en_w),
        .ps  (ps_w),
        .rd  (rd_data)
    );

    assign pwr_state = ps_w;
endmodule

// File: rtl/pm_csr_chk.sv
module pm_csr_chk (
    input logic        clk,
    input logic        gl_rst,
    input logic        bus_rst,
    input logic        wake_evt,
    input logic [15:0] rd_data,
    input logic        wake_req,
    input logic [1:0]  pwr_state,
    input logic        fn_rst_pulse
);
    assert_req_bits_R7: assert property (@(posedge clk) disable iff (gl_rst)
        wake_req == (rd_data[15] && rd_data[8]));

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (gl_rst)
        fn_rst_pulse |=> !fn_rst_pulse);

    assert_pulse_from_d3_R9: assert property (@(posedge clk) disable iff (gl_rst)
        fn_rst_pulse |-> (pwr_state == 2'b00 && $past(pwr_state) == 2'b11));

    assert_evt_sets_R5: assert property (@(posedge clk) disable iff (gl_rst)
        (wake_evt && !bus_rst) |=> rd_data[15]);

    assert_en_survives_bus_R4: assert property (@(posedge clk) disable iff (gl_rst)
        (bus_rst && rd_data[8]) |=> rd_data[8]);

    assert_ctx_kept_R8: assert property (@(posedge clk) disable iff (gl_rst)
        (bus_rst && rd_data[8] && rd_data[15]) |=> rd_data[15]);

    assert_bus_state_R3: assert property (@(posedge clk) disable iff (gl_rst)
        bus_rst |=> (pwr_state == 2'b00));
endmodule

bind pm_csr_top pm_csr_chk chk_i (
    .clk         (clk),
    .gl_rst      (gl_rst),
    .bus_rst     (bus_rst),
    .wake_evt    (wake_evt),
    .rd_data     (rd_data),
    .wake_req    (wake_req),
    .pwr_state   (pwr_state),
    .fn_rst_pulse(fn_rst_pulse)
);

// File: tb/pm_csr_top_tb.sv
module pm_csr_top_tb_top;
    logic        clk = 1'b0;
    logic        gl_rst = 1'b1;
    logic        bus_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = 16'h0;
    logic        wake_evt = 1'b0;
    logic [15:0] rd_data;
    logic        wake_req;
    logic [1:0]  pwr_state;
    logic        fn_rst_pulse;

    int tests = 0;
    int fails = 0;
    bit started = 0;
    bit done = 0;

    // reference model state
    int m_st = 0, m_en = 0, m_ps = 0, m_pulse = 0;

    always #2 clk = ~clk;

    pm_csr_top dut_i (
        .clk(clk), .gl_rst(gl_rst), .bus_rst(bus_rst), .wr_en(wr_en),
        .wr_be(wr_be), .wr_data(wr_data), .wake_evt(wake_evt),
        .rd_data(rd_data), .wake_req(wake_req), .pwr_state(pwr_state),
        .fn_rst_pulse(fn_rst_pulse)
    );

    always @(posedge clk) begin
        int nst;
        started = 1;
        if (gl_rst) begin
            m_st = 0; m_en = 0; m_ps = 0; m_pulse = 0;
        end else if (bus_rst) begin
            if (m_en == 0) m_st = 0;
            m_ps = 0; m_pulse = 0;
        end else begin
            m_pulse = (wr_en && wr_be[0] && m_ps == 3 && wr_data[1:0] == 2'b00) ? 1 : 0;
            nst = (wake_evt || (m_st == 1 && !(wr_en && wr_be[1] && wr_data[15]))) ? 1 : 0;
            if (wr_en && wr_be[1]) m_en = wr_data[8];
            if (wr_en && wr_be[0]) m_ps = wr_data[1:0];
            m_st = nst;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            chk("R1/R6 status bit15", rd_data[15], m_st);
            chk("R4/R10 enable bit8", rd_data[8], m_en);
            chk("R2 zero bits", {rd_data[14:9], rd_data[7:2]}, 0);
            chk("R3 state bits1:0", rd_data[1:0], m_ps);
            chk("R3 pwr_state port", pwr_state, m_ps);
            chk("R7 wake_req", wake_req, (m_st & m_en));
            chk("R9 fn_rst_pulse", fn_rst_pulse, m_pulse);
        end
    end

    task automatic cyc(input bit w, input bit [1:0] be, input bit [15:0] d,
                       input bit ev, input bit br);
        wr_en = w; wr_be = be; wr_data = d; wake_evt = ev; bus_rst = br;
        @(negedge clk);
        wr_en = 0; wr_be = 0; wake_evt = 0; bus_rst = 0;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        gl_rst = 0;
        // R1: reset state
        chk("R1 reset value", rd_data, 16'h0000);
        // R2/R10: all ones both lanes; bit15 write-1 is clear
        cyc(1, 2'b11, 16'hFFFF, 0, 0);
        chk("R2 ones write", rd_data, 16'h0103);
        // R5: event sets status, enable on -> request
        cyc(0, 2'b00, 16'h0, 1, 0);
        chk("R5 event", rd_data, 16'h8103);
        // R6: write 0 to bit15 no effect
        cyc(1, 2'b10, 16'h0100, 0, 0);
        chk("R6 write0", rd_data[15], 1);
        // R9: D3hot -> D0 with be0 only
        cyc(1, 2'b01, 16'h0000, 0, 0);
        chk("R9 pulse", fn_rst_pulse, 1);
        chk("R9 regs kept", rd_data, 16'h8100);
        cyc(0, 2'b00, 16'h0, 0, 0);
        chk("R9 single", fn_rst_pulse, 0);
        // R9: D3hot -> D1 no pulse; D3hot->D3hot no pulse
        cyc(1, 2'b01, 16'h0003, 0, 0);
        cyc(1, 2'b01, 16'h0003, 0, 0);
        chk("R9 d3->d3", fn_rst_pulse, 0);
        cyc(1, 2'b01, 16'h0001, 0, 0);
        chk("R9 d3->d1", fn_rst_pulse, 0);
        // R10: masked lane 0 write, data 0
        cyc(1, 2'b10, 16'h0100, 0, 0);
        chk("R10 lane0 masked", rd_data[1:0], 2'b01);
        // R8: bus reset with enable keeps status
        cyc(0, 2'b00, 16'h0, 0, 1);
        chk("R8 ctx kept", rd_data, 16'h8100);
        // R6: clear and event same cycle
        cyc(1, 2'b10, 16'h8100, 1, 0);
        chk("R6 collide", rd_data[15], 1);
        cyc(1, 2'b10, 16'h8000, 0, 0);
        chk("R6 clear", rd_data, 16'h0000);
        // R5 with enable off; R8 bus reset clears
        cyc(0, 2'b00, 16'h0, 1, 0);
        chk("R5 event no enable", rd_data[15], 1);
        chk("R7 no req", wake_req, 0);
        cyc(1, 2'b11, 16'h0103, 1, 1);
        chk("R8 cleared", rd_data, 16'h0000);
        // random traffic
        for (int i = 0; i < 2000; i++) begin
            bit [31:0] r;
            r = $urandom;
            cyc(r[0], r[2:1], r[31:16], r[3] & r[4], (r[7:5] == 3'b000));
            if (r[11:8] == 4'h0) begin
                gl_rst = 1;
                @(negedge clk);
                gl_rst = 0;
            end
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule